// File: doc/BRIEF.md
# Counter-Based Frequency-Locking Controller

This block steers a digitally controlled oscillator onto a target frequency. It counts the rising edges of each of two oscillators, a main one and a replica, over a window set in reference-clock cycles. A toggle handshake brings each count into the reference domain. The count from the selected channel is compared with a programmable frequency-control word. The signed error drives a proportional-plus-integral filter. The filter result becomes one of three commands: raise, lower or hold. Each command moves a cascaded coarse/medium/fine tuning code by at most one fine step.

The loop never stops. After lock it keeps measuring and stepping, so slow supply and temperature drift is followed. A deadband around zero filter output gives the hold command, which keeps the code from dithering. A lock flag reports a run of consecutive holds. It drops only when the error leaves a wider unlock threshold.

The sequencer is a three-state machine:
- ST_WAIT waits for a measurement from the selected channel and goes to ST_FILT when one arrives.
- ST_FILT updates the integral and the filter result and always goes on to ST_DECIDE.
- ST_DECIDE issues the command, steps the tuning code, updates the lock flag and always returns to ST_WAIT.

Reset returns the machine to ST_WAIT.

Top module: `freq_lock_ctrl`

## Requirements
- R1: `freq_count` gives the number of rising edges of the selected oscillator in each window of `window_len` reference cycles, with `window_len` at least 8. The first window after reset is discarded, and one new count arrives per window.
- R2: `use_replica` = 0 selects the main oscillator channel and `use_replica` = 1 selects the replica channel.
- R3: The error is e = count − fcw, a signed value. The accumulator holds the sum of all errors since reset, including the current one. The filter result is y = e·2^KP_SH + (acc >>> KI_SH), an arithmetic shift. The defaults are KP_SH = 1 and KI_SH = 2.
- R4: Each window produces exactly one `cmd_valid` pulse of one cycle. If y > deadband, `cmd` = 2'b10 (lower). If y < −deadband, `cmd` = 2'b01 (raise). Otherwise `cmd` = 2'b00 (hold).
- R5: The accumulator saturates at its signed limits and never wraps. A long, constant negative error therefore produces only raise commands.
- R6: Raise adds one to the fine field. When the fine field is at its maximum, it returns to mid-scale and the medium field gains one. Lower works the same way in the other direction, with the carry taken when the fine field is at 0.
- R7: A medium field that must carry past its limit returns to mid-scale, the fine field goes to mid-scale, and the coarse field steps by one.
- R8: At full-scale code (7,15,15), raise leaves the code unchanged. At all-zero code, lower leaves the code unchanged.
- R9: Hold leaves the tuning code unchanged. The code changes only in a cycle where `cmd_valid` is high, at the same edge as the command.
- R10: `locked` rises on the LOCK_N-th consecutive hold command (default 4), in the same cycle as that command.
- R11: `locked` clears when |e| > `unlock_thr`. It stays set through any command whose error lies within the threshold, including raise and lower.
- R12: Synchronous reset does the following:
  - loads mid-scale code (coarse 4, medium 8, fine 8);
  - clears `locked` and `cmd_valid`;
  - clears the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_main | input | 1 | Main oscillator output |
| osc_replica | input | 1 | Replica oscillator output |
| use_replica | input | 1 | Channel select for the loop: 0 main, 1 replica |
| fcw | input | 12 | Target edge count per window |
| window_len | input | 10 | Window length in reference cycles (at least 8) |
| deadband | input | 8 | Half-width of the hold band on the filter result |
| unlock_thr | input | 12 | Error magnitude above which lock drops |
| freq_count | output | 12 | Last measured edge count |
| cmd | output | 2 | 00 hold, 01 raise, 10 lower |
| cmd_valid | output | 1 | One-cycle pulse per decision |
| tune_coarse | output | 3 | Coarse tuning field |
| tune_medium | output | 4 | Medium tuning field |
| tune_fine | output | 4 | Fine tuning field |
| locked | output | 1 | Lock indication |

## Verification
The oscillators run open loop at fixed periods, 4 ns and 5 ns, against a 320 ns window. This gives known counts of 80 and 64. A table of target words and deadbands then yields errors that land just inside, exactly on, and just outside the hold band. These cases separate the sign convention and the deadband comparison from the proportional weight. Long runs at a constant error cover the following:
- the fine, medium and coarse carries;
- full-scale saturation;
- absence of accumulator wrap, which would flip the command to lower.

A sequence of small errors tells the integral contribution apart from the proportional one, because the command changes only after several windows. The same sequence shows that lock survives non-hold commands while a larger error clears it.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_RAISE = 2'b01,
        CMD_LOWER = 2'b10
    } cmd_e;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'b00,
        ST_FILT   = 2'b01,
        ST_DECIDE = 2'b10
    } st_e;
endpackage

// File: rtl/flc_chan.sv
module flc_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_clk,
    input  logic             sample_req,
    output logic [CNT_W-1:0] cnt_o,
    output logic             vld_o
);
    // reference-domain request toggle
    logic req_tgl;
    always_ff @(posedge clk) begin
        if (rst)             req_tgl <= 1'b0;
        else if (sample_req) req_tgl <= ~req_tgl;
    end

    // oscillator domain: reset synchronizer, edge counter, snapshot
    logic             orst_s1, orst_s2;
    logic [2:0]       req_sh;
    logic [CNT_W-1:0] ocnt, snap;
    logic             ack_tgl;

    always_ff @(posedge osc_clk) begin
        orst_s1 <= rst;
        orst_s2 <= orst_s1;
    end

    always_ff @(posedge osc_clk) begin
        if (orst_s2) begin
            req_sh  <= '0;
            ocnt    <= '0;
            snap    <= '0;
            ack_tgl <= 1'b0;
        end else begin
            req_sh <= {req_sh[1:0], req_tgl};
            ocnt   <= ocnt + 1'b1;
            if (req_sh[2] ^ req_sh[1]) begin
                snap    <= ocnt;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    // reference domain: acknowledge synchronizer and window delta
    logic [2:0]       ack_sh;
    logic [CNT_W-1:0] prev;
    logic             primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_sh <= '0;
            prev   <= '0;
            primed <= 1'b0;
            cnt_o  <= '0;
            vld_o  <= 1'b0;
        end else begin
            ack_sh <= {ack_sh[1:0], ack_tgl};
            vld_o  <= 1'b0;
            if (ack_sh[2] ^ ack_sh[1]) begin
                prev   <= snap;
                primed <= 1'b1;
                if (primed) begin
                    cnt_o <= snap - prev;
                    vld_o <= 1'b1;
                end
            end
        end
    end

    p_single_vld_r1: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);
endmodule

// File: rtl/flc_filter.sv
module flc_filter
    import flc_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int ACC_W = 16,
    parameter int KP_SH = 1,
    parameter int KI_SH = 2,
    parameter int DB_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        fcw,
    input  logic [DB_W-1:0]         deadband,
    output logic signed [CNT_W:0]   err_o,
    output cmd_e                    dec_o
);
    localparam int ERR_W = CNT_W + 1;
    localparam int SUM_W = ACC_W + 1;
    localparam int Y_W   = ACC_W + KP_SH + 2;
    localparam logic signed [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ERR_W-1:0] e;
    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_q, acc_n;
    logic signed [Y_W-1:0]   y_q, y_n, db_s;

    always_comb begin
        e   = $signed({1'b0, cnt}) - $signed({1'b0, fcw});
        sum = SUM_W'(acc_q) + SUM_W'(e);
        if (sum > SUM_W'(A_MAX))      acc_n = A_MAX;
        else if (sum < SUM_W'(A_MIN)) acc_n = A_MIN;
        else                          acc_n = $signed(sum[ACC_W-1:0]);
        y_n  = (Y_W'(e) <<< KP_SH) + (Y_W'(acc_n) >>> KI_SH);
        db_s = Y_W'($signed({1'b0, deadband}));
        if (y_q > db_s)       dec_o = CMD_LOWER;
        else if (y_q < -db_s) dec_o = CMD_RAISE;
        else                  dec_o = CMD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            y_q   <= '0;
            err_o <= '0;
        end else if (upd) begin
            acc_q <= acc_n;
            y_q   <= y_n;
            err_o <= e;
        end
    end

    p_acc_neg_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (upd && e < 0 && acc_q < 0) |=> acc_q < 0);
    p_acc_pos_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (upd && e > 0 && acc_q > 0) |=> acc_q > 0);
endmodule

// File: rtl/flc_tune.sv
module flc_tune
    import flc_pkg::*;
#(
    parameter int CRS_W = 3,
    parameter int MED_W = 4,
    parameter int FIN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  cmd_e             cmd,
    output logic [CRS_W-1:0] crs,
    output logic [MED_W-1:0] med,
    output logic [FIN_W-1:0] fin
);
    localparam logic [CRS_W-1:0] C_MAX = '1;
    localparam logic [MED_W-1:0] M_MAX = '1;
    localparam logic [FIN_W-1:0] F_MAX = '1;
    localparam logic [CRS_W-1:0] C_MID = CRS_W'(1) << (CRS_W - 1);
    localparam logic [MED_W-1:0] M_MID = MED_W'(1) << (MED_W - 1);
    localparam logic [FIN_W-1:0] F_MID = FIN_W'(1) << (FIN_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            crs <= C_MID;
            med <= M_MID;
            fin <= F_MID;
        end else if (step) begin
            unique case (cmd)
                CMD_RAISE: begin
                    if (fin != F_MAX) fin <= fin + 1'b1;
                    else if (med != M_MAX) begin
                        fin <= F_MID;
                        med <= med + 1'b1;
                    end else if (crs != C_MAX) begin
                        fin <= F_MID;
                        med <= M_MID;
                        crs <= crs + 1'b1;
                    end
                end
                CMD_LOWER: begin
                    if (fin != '0) fin <= fin - 1'b1;
                    else if (med != '0) begin
                        fin <= F_MID;
                        med <= med - 1'b1;
                    end else if (crs != '0) begin
                        fin <= F_MID;
                        med <= M_MID;
                        crs <= crs - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    p_fine_up_r6: assert property (@(posedge clk) disable iff (rst)
        (step && cmd == CMD_RAISE && fin != F_MAX) |=> fin == $past(fin) + 1'b1);
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!step || cmd == CMD_HOLD) |=> $stable({crs, med, fin}));
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
    import flc_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int WIN_W  = 10,
    parameter int DB_W   = 8,
    parameter int ACC_W  = 16,
    parameter int KP_SH  = 1,
    parameter int KI_SH  = 2,
    parameter int CRS_W  = 3,
    parameter int MED_W  = 4,
    parameter int FIN_W  = 4,
    parameter int LOCK_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_main,
    input  logic             osc_replica,
    input  logic             use_replica,
    input  logic [CNT_W-1:0] fcw,
    input  logic [WIN_W-1:0] window_len,
    input  logic [DB_W-1:0]  deadband,
    input  logic [CNT_W-1:0] unlock_thr,
    output logic [CNT_W-1:0] freq_count,
    output logic [1:0]       cmd,
    output logic             cmd_valid,
    output logic [CRS_W-1:0] tune_coarse,
    output logic [MED_W-1:0] tune_medium,
    output logic [FIN_W-1:0] tune_fine,
    output logic             locked
);
    localparam int NCH   = 2;
    localparam int LCK_W = $clog2(LOCK_N + 1);

    // window timer
    logic [WIN_W-1:0] wcnt;
    logic             tick;
    assign tick = (wcnt >= window_len - 1'b1);
    always_ff @(posedge clk) begin
        if (rst) wcnt <= '0;
        else     wcnt <= tick ? '0 : wcnt + 1'b1;
    end

    // counter channels
    logic [NCH-1:0]   osc_bus;
    logic [CNT_W-1:0] ch_cnt [NCH];
    logic [NCH-1:0]   ch_vld;
    assign osc_bus = {osc_replica, osc_main};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        flc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .osc_clk   (osc_bus[g]),
            .sample_req(tick),
            .cnt_o     (ch_cnt[g]),
            .vld_o     (ch_vld[g])
        );
    end

    logic             sel_vld;
    logic [CNT_W-1:0] sel_cnt;
    assign sel_vld = ch_vld[use_replica];
    assign sel_cnt = ch_cnt[use_replica];

    // sequencer
    st_e state, state_n;
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_WAIT:   if (sel_vld) state_n = ST_FILT;
            ST_FILT:   state_n = ST_DECIDE;
            ST_DECIDE: state_n = ST_WAIT;
            default:   state_n = ST_WAIT;
        endcase
    end

    logic signed [CNT_W:0] err;
    logic [CNT_W:0]        err_abs;
    cmd_e                  dec, cmd_q;

    flc_filter #(
        .CNT_W(CNT_W), .ACC_W(ACC_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .DB_W(DB_W)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .upd     (state == ST_FILT),
        .cnt     (freq_count),
        .fcw     (fcw),
        .deadband(deadband),
        .err_o   (err),
        .dec_o   (dec)
    );

    flc_tune #(.CRS_W(CRS_W), .MED_W(MED_W), .FIN_W(FIN_W)) u_tune (
        .clk (clk),
        .rst (rst),
        .step(state == ST_DECIDE),
        .cmd (dec),
        .crs (tune_coarse),
        .med (tune_medium),
        .fin (tune_fine)
    );

    assign err_abs = err[CNT_W] ? $unsigned(-err) : $unsigned(err);

    // outputs
    logic [LCK_W-1:0] hold_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            freq_count <= '0;
            cmd_q      <= CMD_HOLD;
            cmd_valid  <= 1'b0;
            locked     <= 1'b0;
            hold_cnt   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            unique case (state)
                ST_WAIT: if (sel_vld) freq_count <= sel_cnt;
                ST_FILT: ;
                ST_DECIDE: begin
                    cmd_q     <= dec;
                    cmd_valid <= 1'b1;
                    if (err_abs > {1'b0, unlock_thr}) begin
                        locked   <= 1'b0;
                        hold_cnt <= '0;
                    end else if (dec == CMD_HOLD) begin
                        if (hold_cnt != LCK_W'(LOCK_N)) hold_cnt <= hold_cnt + 1'b1;
                        if (hold_cnt >= LCK_W'(LOCK_N - 1)) locked <= 1'b1;
                    end else begin
                        hold_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cmd = cmd_q;

    p_cmd_legal_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd != 2'b11);
    p_lock_on_hold_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (cmd_valid && cmd == 2'b00));
    p_unlock_on_decision_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> cmd_valid);
    p_code_moves_with_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({tune_coarse, tune_medium, tune_fine}) |-> cmd_valid);
endmodule

// File: tb/freq_lock_ctrl_tb.sv
`timescale 1ns/1ps
module freq_lock_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_main = 1'b0;
    logic        osc_replica = 1'b0;
    logic        use_replica = 1'b0;
    logic [11:0] fcw = 12'd80;
    logic [9:0]  window_len = 10'd16;
    logic [7:0]  deadband = 8'd2;
    logic [11:0] unlock_thr = 12'd5;
    logic [11:0] freq_count;
    logic [1:0]  cmd;
    logic        cmd_valid;
    logic [2:0]  tune_coarse;
    logic [3:0]  tune_medium;
    logic [3:0]  tune_fine;
    logic        locked;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    freq_lock_ctrl u_dut (
        .clk(clk), .rst(rst), .osc_main(osc_main), .osc_replica(osc_replica),
        .use_replica(use_replica), .fcw(fcw), .window_len(window_len),
        .deadband(deadband), .unlock_thr(unlock_thr), .freq_count(freq_count),
        .cmd(cmd), .cmd_valid(cmd_valid), .tune_coarse(tune_coarse),
        .tune_medium(tune_medium), .tune_fine(tune_fine), .locked(locked)
    );

    always #10 clk = ~clk;

    // edges offset by 0.137 ns from the reference grid: 4 ns and 5 ns periods
    initial begin
        #1.137;
        forever #2.0 osc_main = ~osc_main;
    end
    initial begin
        #1.137;
        forever #2.5 osc_replica = ~osc_replica;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_decision();
        int guard = 0;
        @(negedge clk);
        while (!cmd_valid && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        if (!cmd_valid) begin
            checks++;
            errors++;
            $display("FAIL R4: no decision, actual=0 expected=1");
        end
    endtask

    function automatic int code3(input int c, input int m, input int f);
        return c * 256 + m * 16 + f;
    endfunction

    localparam int V_N = 8;
    localparam int V_REP [V_N] = '{0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_FCW [V_N] = '{80, 70, 81, 81, 79, 79, 80, 60};
    localparam int V_DB  [V_N] = '{2, 2, 2, 3, 3, 1, 2, 2};
    localparam int V_CNT [V_N] = '{80, 80, 80, 80, 80, 80, 64, 64};
    localparam int V_CMD [V_N] = '{0, 2, 1, 0, 0, 2, 1, 2};
    localparam int V_FIN [V_N] = '{8, 7, 9, 8, 8, 7, 9, 7};

    initial begin
        int bad;
        // R12 reset state
        repeat (4) @(negedge clk);
        check("R12 reset code", code3(tune_coarse, tune_medium, tune_fine), code3(4, 8, 8));
        check("R12 reset locked", locked, 0);
        check("R12 reset cmd_valid", cmd_valid, 0);
        rst = 1'b0;

        // R5 saturation: e = -920 for 60 windows, only raise expected
        fcw = 12'd1000;
        do_reset();
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            wait_decision();
            if (cmd != 2'b01) bad++;
        end
        check("R5 non-raise decisions", bad, 0);

        // R12 reset mid-run and table; first vector also shows acc cleared
        for (int v = 0; v < V_N; v++) begin
            use_replica = V_REP[v][0];
            fcw = 12'(V_FCW[v]);
            deadband = 8'(V_DB[v]);
            do_reset();
            if (v == 0) begin
                check("R12 code after run", code3(tune_coarse, tune_medium, tune_fine), code3(4, 8, 8));
                check("R12 locked after run", locked, 0);
            end
            wait_decision();
            check($sformatf("R1 R2 count v%0d", v), freq_count, V_CNT[v]);
            check($sformatf("R3 R4 cmd v%0d", v), cmd, V_CMD[v]);
            check($sformatf("R6 R9 fine v%0d", v), tune_fine, V_FIN[v]);
        end
        use_replica = 1'b0;

        // R10 R11 lock sequence
        fcw = 12'd80; deadband = 8'd2;
        do_reset();
        for (int i = 1; i <= 4; i++) begin
            wait_decision();
            if (i == 3) check("R10 not locked after 3 holds", locked, 0);
        end
        check("R10 locked on 4th hold", locked, 1);
        check("R9 hold keeps code", code3(tune_coarse, tune_medium, tune_fine), code3(4, 8, 8));
        fcw = 12'd81; deadband = 8'd3;
        wait_decision();
        check("R3 first small error holds", cmd, 0);
        for (int i = 2; i <= 5; i++) wait_decision();
        check("R3 integral forces raise", cmd, 1);
        check("R11 lock kept within threshold", locked, 1);
        check("R6 raise steps fine", tune_fine, 9);
        fcw = 12'd90;
        wait_decision();
        check("R11 lock cleared on wide error", locked, 0);

        // R6 R7 R8 upward carries and saturation
        fcw = 12'd100; deadband = 8'd2;
        do_reset();
        bad = 0;
        for (int i = 1; i <= 256; i++) begin
            wait_decision();
            if (cmd != 2'b01) bad++;
            if (i == 8)   check("R6 fine carry", code3(tune_coarse, tune_medium, tune_fine), code3(4, 9, 8));
            if (i == 64)  check("R7 medium carry", code3(tune_coarse, tune_medium, tune_fine), code3(5, 8, 8));
            if (i == 255) check("R8 full scale", code3(tune_coarse, tune_medium, tune_fine), code3(7, 15, 15));
            if (i == 256) check("R8 stays at full scale", code3(tune_coarse, tune_medium, tune_fine), code3(7, 15, 15));
        end
        check("R4 raise run", bad, 0);

        // R6 downward borrow
        fcw = 12'd60;
        do_reset();
        for (int i = 1; i <= 9; i++) begin
            wait_decision();
            if (i == 8) check("R6 fine at zero", code3(tune_coarse, tune_medium, tune_fine), code3(4, 8, 0));
        end
        check("R6 fine borrow", code3(tune_coarse, tune_medium, tune_fine), code3(4, 7, 8));

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule